// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a successive-approximation converter. On a start request it optionally waits out an acquisition interval, switches the sampler to hold, and then walks a binary search from the most significant bit downwards. It drives a trial code to an external DAC and reads back a single comparator decision for each bit. When the last bit is decided it stores the final code in a result register and releases the sampler back to tracking. One cycle later it drops its busy flag and pulses a done strobe.

A length bit sampled together with the start request picks a full 12-bit search or a shortened 8-bit search. In the shortened search the four low result bits are forced to zero. A mode bit, also sampled at start, inserts an acquisition wait before the first trial. This is for front ends whose input may still be settling when the command arrives. Start requests that arrive while a conversion is under way have no effect.

The bit period and the acquisition wait are parameters given in clock cycles. With the defaults at 50 MHz, a full search takes about 18 µs, a short search about 12 µs, and the acquisition wait about 4 µs.

Top module: `sar_sequencer`

## Requirements
- R1: A synchronous active-low reset sets busy, hold and done low and clears result to 0; the block then waits in the tracking state.
- R2: When start is high in a cycle where busy is low, the request is accepted and busy is high from the next cycle on.
- R3: With emul_mode=0 at start, hold goes high in the cycle after start. With emul_mode=1, hold stays low for ACQ_CYCLES cycles after start and then goes high.
- R4: The first trial code is 0x800, with only the MSB set. Each bit is presented for CYC_PER_BIT cycles, from MSB to LSB. At the end of its period the bit is kept when cmp_in=1 (input at or above the trial level) and cleared when cmp_in=0.
- R5: With short_sel=0 at start, 12 bits are decided. The result equals the code the search converges to. Busy stays high for (emul_mode ? ACQ_CYCLES : 0) + 12*CYC_PER_BIT + 1 cycles.
- R6: With short_sel=1 at start, only 8 bits are decided and result[3:0] reads 0. Busy stays high for (emul_mode ? ACQ_CYCLES : 0) + 8*CYC_PER_BIT + 1 cycles. Later changes of short_sel have no effect on that conversion.
- R7: Hold falls in the same cycle that result is updated, which is one cycle before busy falls.
- R8: Start requests while busy is high are ignored. They neither restart the search nor relatch short_sel or emul_mode.
- R9: Done is high for exactly one cycle, the first cycle in which busy is low after a conversion.
- R10: Result changes only at the end of a conversion and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Conversion request, sampled each cycle |
| short_sel | input | 1 | 1 = 8-bit search, 0 = 12-bit search; latched at start |
| emul_mode | input | 1 | 1 = insert acquisition wait before the search; sampled at start |
| cmp_in | input | 1 | Comparator decision: 1 = input at or above trial_code |
| trial_code | output | 12 | Trial code to the DAC |
| hold | output | 1 | 1 = sampler holds, 0 = sampler tracks |
| busy | output | 1 | High while a conversion is in progress |
| done | output | 1 | One-cycle pulse as busy falls |
| result | output | 12 | Last conversion result |

## Verification
The embedded properties check the following on every cycle: how start is acknowledged, whether hold rises at once or after the wait, that the first trial is the MSB, and how each decision adds or keeps set bits. They also check that hold falls with the result update one cycle ahead of busy, that done coincides with the fall of busy, that result is stable between conversions, and that short results have zero low bits. Only the bench scenarios can show that the search converges to the right code for a given comparator threshold, that the busy and hold durations match the chosen length and mode, and that start pulses and length changes during a conversion leave it untouched. The bench also covers recovery from a reset taken mid-conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        SEQ_TRACK   = 2'd0,
        SEQ_ACQUIRE = 2'd1,
        SEQ_SEARCH  = 2'd2,
        SEQ_WRAP    = 2'd3
    } seq_state_e;
endpackage

// File: rtl/sar_tick_counter.sv
module sar_tick_counter #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic last
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart || cnt_q == TOP) cnt_d = '0;
        else                         cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == TOP);
endmodule

// File: rtl/sar_search_reg.sv
module sar_search_reg #(
    parameter int unsigned WIDTH      = 12,
    parameter int unsigned SHORT_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step,
    input  logic             short_len,
    input  logic             cmp,
    output logic [WIDTH-1:0] trial,
    output logic [WIDTH-1:0] resolved,
    output logic             last_bit
);
    localparam int unsigned IW = $clog2(WIDTH);
    localparam logic [IW-1:0] TOP_IDX    = IW'(WIDTH - 1);
    localparam logic [IW-1:0] STOP_SHORT = IW'(WIDTH - SHORT_BITS);

    typedef struct packed {
        logic [WIDTH-1:0] trial;
        logic [IW-1:0]    idx;
    } sr_t;

    sr_t d, q;

    always_comb begin
        resolved        = q.trial;
        resolved[q.idx] = cmp;
    end

    assign last_bit = (q.idx == (short_len ? STOP_SHORT : '0));

    always_comb begin
        d = q;
        if (init) begin
            d.trial = '0;
            d.trial[WIDTH-1] = 1'b1;
            d.idx   = TOP_IDX;
        end else if (step) begin
            if (last_bit) begin
                d.trial = '0;
                d.idx   = '0;
            end else begin
                d.trial = resolved;
                d.trial[q.idx - IW'(1)] = 1'b1;
                d.idx   = q.idx - IW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign trial = q.trial;

    // R4: a kept decision adds the next trial bit, a cleared one swaps it
    p_keep_adds_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step && cmp && !last_bit |=> $countones(trial) == $countones($past(trial)) + 1);
    p_clear_swaps_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step && !cmp && !last_bit |=> $countones(trial) == $countones($past(trial)));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
    parameter int unsigned WIDTH       = 12,
    parameter int unsigned SHORT_BITS  = 8,
    parameter int unsigned CYC_PER_BIT = 75,
    parameter int unsigned ACQ_CYCLES  = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             short_sel,
    input  logic             emul_mode,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] trial_code,
    output logic             hold,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result
);
    import sar_pkg::*;

    localparam int unsigned FULL_CONV_CYCLES  = WIDTH * CYC_PER_BIT;
    localparam int unsigned SHORT_CONV_CYCLES = SHORT_BITS * CYC_PER_BIT;
    localparam int unsigned LOW_BITS          = WIDTH - SHORT_BITS;
    localparam logic [WIDTH-1:0] MSB_ONLY     = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        seq_state_e       state;
        logic             busy;
        logic             hold;
        logic             done;
        logic             len;
        logic [WIDTH-1:0] result;
    } seq_t;

    seq_t d, q;

    logic acq_restart, bit_restart, sr_init, sr_step;
    logic acq_last, bit_last, sr_last;
    logic [WIDTH-1:0] sr_resolved;

    generate
        if (ACQ_CYCLES > 0) begin : g_acq_wait
            sar_tick_counter #(.LIMIT(ACQ_CYCLES)) u_acq_cnt (
                .clk(clk), .rst_n(rst_n), .restart(acq_restart), .last(acq_last)
            );
        end else begin : g_no_acq_wait
            assign acq_last = 1'b1;
        end
    endgenerate

    sar_tick_counter #(.LIMIT(CYC_PER_BIT)) u_bit_cnt (
        .clk(clk), .rst_n(rst_n), .restart(bit_restart), .last(bit_last)
    );

    sar_search_reg #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS)) u_search (
        .clk(clk), .rst_n(rst_n), .init(sr_init), .step(sr_step),
        .short_len(q.len), .cmp(cmp_in), .trial(trial_code),
        .resolved(sr_resolved), .last_bit(sr_last)
    );

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        acq_restart = 1'b0;
        bit_restart = 1'b0;
        sr_init     = 1'b0;
        sr_step     = 1'b0;
        unique case (q.state)
            SEQ_TRACK: begin
                if (start) begin
                    d.busy = 1'b1;
                    d.len  = short_sel;
                    if (emul_mode) begin
                        d.state     = SEQ_ACQUIRE;
                        acq_restart = 1'b1;
                    end else begin
                        d.state     = SEQ_SEARCH;
                        d.hold      = 1'b1;
                        bit_restart = 1'b1;
                        sr_init     = 1'b1;
                    end
                end
            end
            SEQ_ACQUIRE: begin
                if (acq_last) begin
                    d.state     = SEQ_SEARCH;
                    d.hold      = 1'b1;
                    bit_restart = 1'b1;
                    sr_init     = 1'b1;
                end
            end
            SEQ_SEARCH: begin
                if (bit_last) begin
                    sr_step = 1'b1;
                    if (sr_last) begin
                        d.result = sr_resolved;
                        d.hold   = 1'b0;
                        d.state  = SEQ_WRAP;
                    end
                end
            end
            SEQ_WRAP: begin
                d.busy  = 1'b0;
                d.done  = 1'b1;
                d.state = SEQ_TRACK;
            end
            default: d.state = SEQ_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = q.busy;
    assign hold   = q.hold;
    assign done   = q.done;
    assign result = q.result;

    // R1: reset leaves the block idle with an empty result
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !hold && !done && result == '0));
    // R2: a start seen while idle is acknowledged next cycle
    p_start_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy);
    // R3: control mode holds at once, emulation mode keeps tracking first
    p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && !emul_mode |=> hold);
    p_acq_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && emul_mode |=> !hold);
    // R4: the search opens on the MSB alone
    p_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(hold) |-> trial_code == MSB_ONLY);
    // R6: a short conversion leaves the low bits clear
    p_short_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && q.len |-> result[LOW_BITS-1:0] == '0);
    // R7: tracking resumes one cycle before busy falls
    p_hold_then_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(hold) |-> busy);
    p_busy_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(hold) |=> !busy);
    // R8: while holding, no restart can shrink the decided bits
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(hold) && hold
        |-> $countones(trial_code) >= $countones($past(trial_code)));
    // R9: done marks exactly the fall of busy
    p_done_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(busy) |-> done);
    p_done_needs_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));
    // R10: result moves only with the end-of-search update
    p_result_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$fell(hold) |-> $stable(result));
endmodule

// File: tb/sar_sequencer_test.sv
module sar_sequencer_test;
    localparam int W   = 12;
    localparam int SB  = 8;
    localparam int CPB = 4;
    localparam int ACQ = 6;
    localparam int NV  = 10;

    // vector: {level[11:0], short_sel, emul_mode}
    localparam logic [13:0] VECS [NV] = '{
        {12'h000, 1'b0, 1'b0},
        {12'hFFF, 1'b0, 1'b0},
        {12'h800, 1'b0, 1'b0},
        {12'h7FF, 1'b0, 1'b1},
        {12'hA5C, 1'b1, 1'b0},
        {12'h123, 1'b0, 1'b1},
        {12'hFFF, 1'b1, 1'b1},
        {12'h00F, 1'b1, 1'b0},
        {12'h555, 1'b0, 1'b0},
        {12'hAAA, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n, start, short_sel, emul_mode, cmp_in;
    logic [W-1:0] level, trial_code, result;
    logic hold, busy, done;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    assign cmp_in = (level >= trial_code);

    sar_sequencer #(.WIDTH(W), .SHORT_BITS(SB), .CYC_PER_BIT(CPB), .ACQ_CYCLES(ACQ)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .short_sel(short_sel),
        .emul_mode(emul_mode), .cmp_in(cmp_in), .trial_code(trial_code),
        .hold(hold), .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Launches one conversion and follows it to the end.
    // noisy=1 keeps start high and flips the selects during busy (R8).
    task automatic convert(input logic [W-1:0] lvl, input logic sh, input logic em, input bit noisy);
        int busy_n = 0;
        int hold_n = 0;
        bit seen = 0;
        int nbits = sh ? SB : W;
        logic [W-1:0] exp_res = sh ? {lvl[W-1:W-SB], {(W-SB){1'b0}}} : lvl;
        level = lvl; short_sel = sh; emul_mode = em; start = 1'b1;
        @(negedge clk);
        short_sel = ~sh;
        emul_mode = ~em;
        if (!noisy) start = 1'b0;
        check(busy === 1'b1, "R2 busy after start", busy, 1);
        if (em) check(hold === 1'b0, "R3 tracking during wait", hold, 0);
        else    check(hold === 1'b1, "R3 hold at once", hold, 1);
        while (busy === 1'b1 && busy_n < 1000) begin
            busy_n++;
            if (hold === 1'b1) begin
                if (!seen) check(trial_code === 12'h800, "R4 first trial", trial_code, 12'h800);
                seen = 1;
                hold_n++;
            end
            if (done !== 1'b0) check(0, "R9 done while busy", done, 0);
            @(negedge clk);
        end
        start = 1'b0;
        check(done === 1'b1, "R9 done at busy fall", done, 1);
        check(result === exp_res, sh ? "R6 short result" : "R5 full result", result, exp_res);
        check(busy_n == (em ? ACQ : 0) + nbits * CPB + 1,
              noisy ? "R8 busy length under restarts" : (sh ? "R6 busy length" : "R5 busy length"),
              busy_n, (em ? ACQ : 0) + nbits * CPB + 1);
        check(hold_n == nbits * CPB, "R7 hold length", hold_n, nbits * CPB);
        @(negedge clk);
        check(done === 1'b0, "R9 done one cycle", done, 0);
        check(result === exp_res, "R10 result held", result, exp_res);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; short_sel = 1'b0; emul_mode = 1'b0; level = '0;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && hold === 1'b0 && done === 1'b0, "R1 idle flags", {busy, hold, done}, 0);
        check(result === '0, "R1 result clear", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0, "R2 no start no busy", busy, 0);

        for (int i = 0; i < NV; i++) begin
            convert(VECS[i][13:2], VECS[i][1], VECS[i][0], 0);
            repeat (2) @(negedge clk);
        end

        // R8: start held high and selects flipped through a full conversion
        convert(12'h9C3, 1'b0, 1'b0, 1);
        repeat (2) @(negedge clk);
        // R8: short conversion in emulation mode, same abuse
        convert(12'h3E7, 1'b1, 1'b1, 1);
        repeat (2) @(negedge clk);

        // R4: exact comparator edge, level equal to a trial keeps the bit
        convert(12'hC00, 1'b0, 1'b0, 0);
        repeat (2) @(negedge clk);

        // R1: reset in the middle of a conversion
        level = 12'h456; short_sel = 1'b0; emul_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && hold === 1'b0 && done === 1'b0, "R1 mid-run reset flags", {busy, hold, done}, 0);
        check(result === '0, "R1 mid-run reset result", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0, "R1 stays idle after reset", busy, 0);
        convert(12'h456, 1'b0, 1'b0, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule